// File: doc/BRIEF.md
# Video Capture Crop Window

This block sits between a parallel camera sensor port and the memory writer that stores frames. Every clock it sees a data bus, a valid strobe, a horizontal sync and a vertical sync. It counts the valid bus samples in each line to give a column index. It counts the lines that carried data to give a row index. Only samples whose column and row both fall inside a programmed rectangle are forwarded. Samples outside the rectangle are dropped. The downstream writer therefore never receives more samples than its buffer was sized for, even when the sensor sends larger frames than expected.

The rectangle is given by two 32-bit words, one for columns and one for rows. Each word holds an inclusive minimum and an inclusive maximum. Two enable bits in a control word turn column limiting and row limiting on separately. The block counts bus samples, not pixels. A pixel carried as two bus samples therefore takes two column positions, and the bounds must be programmed in samples. Window settings are captured at the start of each frame. The output is a registered sample stream that carries a frame-start marker and a line-start marker.

Top module: `video_crop_window`

## Requirements
- R1: After reset all outputs are 0. No sample is forwarded until the first rising edge of `in_vsync` has been seen, even when valid samples and line syncs arrive before it.
- R2: The column index is the number of earlier valid samples since the latest rising edge of `in_hsync`, so the first sample of a line is column 0. Every valid bus sample counts. With column limiting on, a sample is kept only if `col_win[15:0]` <= column <= `col_win[31:16]`.
- R3: The row index is 0 for the first line after a rising edge of `in_vsync`. It increases by one at each rising edge of `in_hsync` that follows a line containing at least one valid sample, so lines without data are not counted. With row limiting on, a sample is kept only if `row_win[15:0]` <= row <= `row_win[31:16]`.
- R4: `ctrl_word[12]` enables column limiting and `ctrl_word[13]` enables row limiting. When an axis is disabled, samples are not limited along that axis.
- R5: A kept sample shows up on `out_valid` and `out_data` exactly one clock after it is presented. `out_valid` is 0 in every other cycle.
- R6: `out_sof` is 1 together with the first forwarded sample of each frame and 0 at all other times.
- R7: `out_sol` is 1 together with the first forwarded sample of each row and 0 at all other times. `out_sof` is never 1 without `out_sol`.
- R8: The column index saturates at 0xFFFF and does not wrap, so an oversized line cannot re-enter the window.
- R9: `ctrl_word`, `col_win` and `row_win` are captured only in the cycle where `in_vsync` rises. Changes made during a frame take effect from the next frame.
- R10: When both limits are enabled, at most (colmax-colmin+1)*(rowmax-rowmin+1) samples are forwarded per frame. A window with minimum greater than maximum forwards nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Bus sample valid |
| in_data | input | DW | Bus sample |
| in_hsync | input | 1 | Line sync, rising edge starts a line |
| in_vsync | input | 1 | Frame sync, rising edge starts a frame |
| ctrl_word | input | 32 | Control word; bit 12 column enable, bit 13 row enable |
| col_win | input | 32 | Column bounds: [15:0] min, [31:16] max |
| row_win | input | 32 | Row bounds: [15:0] min, [31:16] max |
| out_valid | output | 1 | Forwarded sample valid |
| out_data | output | DW | Forwarded sample |
| out_sof | output | 1 | First forwarded sample of the frame |
| out_sol | output | 1 | First forwarded sample of the row |

## Verification
The bench sweeps every column and row bound pair over a small range, with all four enable combinations. The frames it sends include gaps in the valid strobe and a line without data. An off-by-one in either inclusive bound would show up as one column or row too many or too few. A design that counted empty lines would shift every later row. Several other faults are targeted directly. Samples sent before the first frame sync catch a block that forwards at power-up. A window reprogrammed mid-frame catches configuration that is not held for the whole frame. A single line of more than 65,536 samples catches a column counter that wraps and lets the window open a second time.

// File: rtl/video_crop_window.sv
module video_crop_window #(
  parameter int DW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [DW-1:0] in_data,
  input  logic          in_hsync,
  input  logic          in_vsync,
  input  logic [31:0]   ctrl_word,
  input  logic [31:0]   col_win,
  input  logic [31:0]   row_win,
  output logic          out_valid,
  output logic [DW-1:0] out_data,
  output logic          out_sof,
  output logic          out_sol
);
  localparam int CW = 16;
  localparam logic [CW-1:0] CSAT = '1;

  logic hs_q, vs_q, active, line_has, sof_pend, sol_pend;
  logic [CW-1:0] col_cnt, row_cnt;
  logic [CW-1:0] cmin_q, cmax_q, rmin_q, rmax_q;
  logic cen_q, ren_q;

  wire hs_edge = in_hsync & ~hs_q;
  wire vs_edge = in_vsync & ~vs_q;

  wire [CW-1:0] cmin_e = vs_edge ? col_win[15:0]  : cmin_q;
  wire [CW-1:0] cmax_e = vs_edge ? col_win[31:16] : cmax_q;
  wire [CW-1:0] rmin_e = vs_edge ? row_win[15:0]  : rmin_q;
  wire [CW-1:0] rmax_e = vs_edge ? row_win[31:16] : rmax_q;
  wire          cen_e  = vs_edge ? ctrl_word[12]  : cen_q;
  wire          ren_e  = vs_edge ? ctrl_word[13]  : ren_q;

  wire [CW-1:0] row_inc = (row_cnt == CSAT) ? row_cnt : row_cnt + 1'b1;
  wire [CW-1:0] col_e   = (hs_edge | vs_edge) ? '0 : col_cnt;
  wire [CW-1:0] row_e   = vs_edge ? '0 : (hs_edge & line_has) ? row_inc : row_cnt;
  wire [CW-1:0] col_inc = (col_e == CSAT) ? col_e : col_e + 1'b1;

  wire had_e  = ~(hs_edge | vs_edge) & line_has;
  wire act_e  = active | vs_edge;
  wire sofp_e = vs_edge | sof_pend;
  wire solp_e = vs_edge | hs_edge | sol_pend;

  wire col_ok = ~cen_e | ((col_e >= cmin_e) & (col_e <= cmax_e));
  wire row_ok = ~ren_e | ((row_e >= rmin_e) & (row_e <= rmax_e));
  wire take   = in_valid & act_e & col_ok & row_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hs_q <= 1'b0; vs_q <= 1'b0; active <= 1'b0; line_has <= 1'b0;
      sof_pend <= 1'b0; sol_pend <= 1'b0;
      col_cnt <= '0; row_cnt <= '0;
      cmin_q <= '0; cmax_q <= '0; rmin_q <= '0; rmax_q <= '0;
      cen_q <= 1'b0; ren_q <= 1'b0;
      out_valid <= 1'b0; out_data <= '0; out_sof <= 1'b0; out_sol <= 1'b0;
    end else begin
      hs_q     <= in_hsync;
      vs_q     <= in_vsync;
      active   <= act_e;
      line_has <= had_e | in_valid;
      sof_pend <= sofp_e & ~take;
      sol_pend <= solp_e & ~take;
      col_cnt  <= in_valid ? col_inc : col_e;
      row_cnt  <= row_e;
      cmin_q <= cmin_e; cmax_q <= cmax_e; rmin_q <= rmin_e; rmax_q <= rmax_e;
      cen_q  <= cen_e;  ren_q  <= ren_e;
      out_valid <= take;
      out_sof   <= take & sofp_e;
      out_sol   <= take & solp_e;
      if (take) out_data <= in_data;
    end
  end

  // frame output counter used only by the bound check
  logic        fr_q;
  logic [33:0] fwd_cnt;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fr_q <= 1'b0; fwd_cnt <= '0;
    end else begin
      fr_q    <= vs_edge;
      fwd_cnt <= fr_q ? {33'd0, out_valid} : fwd_cnt + {33'd0, out_valid};
    end
  end
  wire [16:0] cspan = {1'b0, cmax_q} - {1'b0, cmin_q} + 17'd1;
  wire [16:0] rspan = {1'b0, rmax_q} - {1'b0, rmin_q} + 17'd1;
  wire [33:0] bound = ((cmax_q >= cmin_q) && (rmax_q >= rmin_q)) ? cspan * rspan : 34'd0;
  wire        bounded = cen_q & ren_q & (cmax_q != CSAT) & (rmax_q != CSAT) & ~fr_q;

  // R5
  out_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid));
  // R6
  sof_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_sof |-> out_valid);
  // R7
  sof_sol_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_sof |-> out_sol);
  // R7
  sol_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_sol |-> out_valid);
  // R8
  col_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (col_cnt == CSAT && !hs_edge && !vs_edge) |=> col_cnt == CSAT);
  // R10
  frame_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bounded |-> fwd_cnt <= bound);
endmodule

// File: tb/test_video_crop_window.sv
`timescale 1ns/1ps
module test_video_crop_window;
  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, in_hsync = 1'b0, in_vsync = 1'b0;
  logic [7:0] in_data = '0;
  logic [31:0] ctrl_word = '0, col_win = '0, row_win = '0;
  logic out_valid, out_sof, out_sol;
  logic [7:0] out_data;

  always #2.5 clk = ~clk;

  video_crop_window #(.DW(8)) i_video_crop_window (
    .clk, .rst_n, .in_valid, .in_data, .in_hsync, .in_vsync,
    .ctrl_word, .col_win, .row_win,
    .out_valid, .out_data, .out_sof, .out_sol);

  int n_chk = 0, n_fail = 0;
  logic e_v = 1'b0, e_sof = 1'b0, e_sol = 1'b0;
  logic [7:0] e_d = '0;
  string e_req = "R1";
  bit done = 0;

  task automatic step(input logic v, input logic [7:0] d, input logic hs, input logic vs,
                      input logic ev, input logic esof, input logic esol, input string req);
    @(negedge clk);
    n_chk++;
    if (out_valid !== e_v || (e_v && out_data !== e_d) || out_sof !== e_sof || out_sol !== e_sol) begin
      n_fail++;
      $display("FAIL %s: got v=%0b d=%0h sof=%0b sol=%0b, expected v=%0b d=%0h sof=%0b sol=%0b",
               e_req, out_valid, out_data, out_sof, out_sol, e_v, e_d, e_sof, e_sol);
    end
    in_valid = v; in_data = d; in_hsync = hs; in_vsync = vs;
    e_v = ev; e_d = d; e_sof = esof; e_sol = esol; e_req = req;
  endtask

  task automatic run_frame(input int nl, input int ns, input bit gaps, input bit blank1,
                           input bit cen, input bit ren, input int cmin, input int cmax,
                           input int rmin, input int rmax, input bit change_mid, input string req);
    bit first = 1;
    int r = 0;
    ctrl_word = 32'h0 | (32'(cen) << 12) | (32'(ren) << 13);
    col_win = {cmax[15:0], cmin[15:0]};
    row_win = {rmax[15:0], rmin[15:0]};
    step(0, 8'h00, 0, 1, 0, 0, 0, req);
    step(0, 8'h00, 0, 0, 0, 0, 0, req);
    for (int li = 0; li < nl; li++) begin
      bit lfirst = 1;
      step(0, 8'h00, 1, 0, 0, 0, 0, req);
      if (change_mid && li == 1) begin
        ctrl_word = ctrl_word ^ 32'h3000; col_win = ~col_win; row_win = ~row_win;
      end
      if (blank1 && li == 1) begin
        for (int k = 0; k < 3; k++) step(0, 8'h00, 0, 0, 0, 0, 0, req);
        continue;
      end
      for (int c = 0; c < ns; c++) begin
        int cc = (c > 65535) ? 65535 : c;
        bit w = (!cen || (cc >= cmin && cc <= cmax)) && (!ren || (r >= rmin && r <= rmax));
        logic [7:0] d = 8'((li * 37 + c) & 8'hff);
        if (gaps && (c % 3 == 1)) step(0, 8'h00, 0, 0, 0, 0, 0, req);
        step(1, d, 0, 0, w, w & first, w & lfirst, req);
        if (w) begin first = 0; lfirst = 0; end
      end
      r++;
    end
    step(0, 8'h00, 0, 0, 0, 0, 0, req);
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout, expected completion");
    finish_up();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    n_chk++;
    if (out_valid !== 1'b0 || out_sof !== 1'b0 || out_sol !== 1'b0 || out_data !== 8'h00) begin
      n_fail++;
      $display("FAIL R1: reset outputs got v=%0b d=%0h sof=%0b sol=%0b, expected all 0",
               out_valid, out_data, out_sof, out_sol);
    end
    rst_n = 1'b1;
    // R1: data before the first frame sync is never forwarded
    step(0, 8'h00, 1, 0, 0, 0, 0, "R1");
    for (int c = 0; c < 8; c++) step(1, 8'(c + 1), 0, 0, 0, 0, 0, "R1");
    step(0, 8'h00, 0, 0, 0, 0, 0, "R1");

    // R2 R3 R4 R5 R6 R7: sweep of bounds and enables
    for (int en = 0; en < 4; en++)
      for (int cmin = 0; cmin < 4; cmin++)
        for (int cmax = cmin; cmax < 4; cmax++)
          for (int rmin = 0; rmin < 3; rmin++)
            for (int rmax = rmin; rmax < 3; rmax++)
              run_frame(4, 6, (cmin + rmin) % 2 == 1, cmax == 3, en[0], en[1],
                        cmin, cmax, rmin, rmax, 0, "R2 R3 R4 R5 R6 R7");

    // R10: empty windows forward nothing
    run_frame(3, 6, 0, 0, 1, 1, 3, 1, 0, 2, 0, "R10");
    run_frame(3, 6, 0, 0, 1, 1, 0, 5, 2, 0, 0, "R10");

    // R9: reprogramming mid-frame has no effect until the next frame
    run_frame(4, 6, 0, 0, 1, 1, 1, 3, 1, 2, 1, "R9");
    run_frame(4, 6, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R9");

    // R8: an oversized line must not wrap back into the window
    run_frame(1, 65545, 0, 0, 1, 0, 0, 3, 0, 0, 0, "R8");
    run_frame(2, 6, 0, 0, 1, 1, 2, 4, 0, 1, 0, "R8");

    finish_up();
  end
endmodule